// File: doc/BRIEF.md
# Flagless Integer Execute Unit

This block is the combinational execute stage of a simple 32-bit three-address processor. It receives an opcode, the first source operand, the second register operand and a 16-bit immediate field. The opcode alone decides the operation and whether the second operand is the register value or the sign-extended immediate. The unit returns one data word and a flag that tells whether the opcode belongs to one of its two operation ranges.

No condition flags exist. A comparison writes its outcome as a whole word: 1 for true and 0 for false. A later conditional branch can test that word for zero or nonzero. Register file access, instruction sequencing and memory are handled outside this unit.

Top module: `flagless_alu`

## Requirements
- R1: Opcodes 10 through 25 take the immediate as second operand and select, in opcode order, add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod; valid_o is 1 for them.
- R2: Opcodes 32 through 47 take src_b_i as second operand, with the same operation order as R1 (32 is add, 47 is mod); valid_o is 1 for them.
- R3: The 16-bit immediate is sign-extended to 32 bits before every immediate-form operation, bitwise ones included.
- R4: add, sub and mul use two's-complement arithmetic and return the low 32 bits of the exact result.
- R5: lt, le, gt and ge compare both operands as signed numbers; every comparison result is exactly 32'd1 when true and 32'd0 when false.
- R6: eq and ne test the full 32-bit equality of the two operands.
- R7: shl and shr shift by the low 5 bits of the second operand only; shr fills with zeros.
- R8: div and mod are signed and truncate toward zero; the remainder takes the sign of the dividend; a zero divisor yields 0 for both; 0x80000000 div -1 gives 0x80000000, and mod gives 0.
- R9: xor with immediate 0xFFFF (opcode 16) returns the bitwise complement of src_a_i.
- R10: Any opcode outside 10..25 and 32..47 gives result_o = 0 and valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Operation code |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate field, signed |
| result_o | output | 32 | Operation result |
| valid_o | output | 1 | Opcode is in an execute range |

## Verification
The bench builds the unit with its default widths: 32-bit data, a 16-bit immediate and a 6-bit opcode. With these widths all 64 opcode values can be reached, so random stimulus covers both operation ranges, the undefined gaps 0..9, 26..31 and 48..63, and the boundary opcodes. Random operands are drawn from a pool that includes 0, -1, 0x80000000 and 0x7FFFFFFF. This pool reaches the signed-compare edges, the one division overflow case and the zero divisor. Shift amounts above 31 are also reached, which tests that only the low five bits of the amount are used.

// File: rtl/flagless_alu_pkg.sv
package flagless_alu_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'd0,  FN_SUB = 4'd1,  FN_MUL = 4'd2,  FN_DIV = 4'd3,
    FN_AND = 4'd4,  FN_OR  = 4'd5,  FN_XOR = 4'd6,  FN_EQ  = 4'd7,
    FN_NE  = 4'd8,  FN_LT  = 4'd9,  FN_LE  = 4'd10, FN_GT  = 4'd11,
    FN_GE  = 4'd12, FN_SHL = 4'd13, FN_SHR = 4'd14, FN_MOD = 4'd15
  } alu_fn_e;

  localparam int unsigned FN_COUNT = 16;

  typedef struct packed {
    alu_fn_e fn;
    logic    use_imm;
    logic    valid;
  } alu_dec_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import flagless_alu_pkg::*;
#(
  parameter int unsigned OP_W     = 6,
  parameter int unsigned IMM_BASE = 10,
  parameter int unsigned REG_BASE = 32
) (
  input  logic [OP_W-1:0] op_i,
  output alu_dec_t        dec_o
);
  localparam int unsigned IMM_LAST = IMM_BASE + FN_COUNT - 1;
  localparam int unsigned REG_LAST = REG_BASE + FN_COUNT - 1;

  logic in_imm, in_reg;
  logic [OP_W-1:0] rel;

  always_comb begin
    in_imm = (32'(op_i) >= IMM_BASE) && (32'(op_i) <= IMM_LAST);
    in_reg = (32'(op_i) >= REG_BASE) && (32'(op_i) <= REG_LAST);
    rel    = '0;
    if (in_imm)      rel = op_i - OP_W'(IMM_BASE);
    else if (in_reg) rel = op_i - OP_W'(REG_BASE);
    dec_o.fn      = alu_fn_e'(rel[3:0]);
    dec_o.use_imm = in_imm;
    dec_o.valid   = in_imm | in_reg;
  end
endmodule

// File: rtl/alu_operand.sv
module alu_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign opnd_o  = use_imm_i ? imm_ext : reg_i;
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o
);
  logic              num_neg, den_neg;
  logic [DATA_W-1:0] num_mag, den_mag, q_mag, r_mag;

  always_comb begin
    num_neg = num_i[DATA_W-1];
    den_neg = den_i[DATA_W-1];
    num_mag = num_neg ? (~num_i + 1'b1) : num_i;
    den_mag = den_neg ? (~den_i + 1'b1) : den_i;
    q_mag   = '0;
    r_mag   = '0;
    if (den_i != '0) begin
      q_mag = num_mag / den_mag;
      r_mag = num_mag % den_mag;
    end
    // quotient sign from both operands, remainder follows dividend
    quo_o = (num_neg ^ den_neg) ? (~q_mag + 1'b1) : q_mag;
    rem_o = num_neg ? (~r_mag + 1'b1) : r_mag;
  end
endmodule

// File: rtl/flagless_alu.sv
module flagless_alu
  import flagless_alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned OP_W     = 6,
  parameter int unsigned IMM_BASE = 10,
  parameter int unsigned REG_BASE = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  alu_dec_t          dec;
  logic [DATA_W-1:0] opnd_b, quo, rem;
  logic [SH_W-1:0]   sh_amt;
  logic              is_eq, is_lt;

  alu_decode #(.OP_W(OP_W), .IMM_BASE(IMM_BASE), .REG_BASE(REG_BASE)) u_dec (
    .op_i  (op_i),
    .dec_o (dec)
  );

  alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .reg_i     (src_b_i),
    .imm_i     (imm_i),
    .use_imm_i (dec.use_imm),
    .opnd_o    (opnd_b)
  );

  alu_divider #(.DATA_W(DATA_W)) u_div (
    .num_i (src_a_i),
    .den_i (opnd_b),
    .quo_o (quo),
    .rem_o (rem)
  );

  assign sh_amt = opnd_b[SH_W-1:0];
  assign is_eq  = (src_a_i == opnd_b);
  assign is_lt  = ($signed(src_a_i) < $signed(opnd_b));

  always_comb begin
    result_o = '0;
    if (dec.valid) begin
      unique case (dec.fn)
        FN_ADD: result_o = src_a_i + opnd_b;
        FN_SUB: result_o = src_a_i - opnd_b;
        FN_MUL: result_o = src_a_i * opnd_b;
        FN_DIV: result_o = quo;
        FN_MOD: result_o = rem;
        FN_AND: result_o = src_a_i & opnd_b;
        FN_OR:  result_o = src_a_i | opnd_b;
        FN_XOR: result_o = src_a_i ^ opnd_b;
        FN_EQ:  result_o = DATA_W'(is_eq);
        FN_NE:  result_o = DATA_W'(!is_eq);
        FN_LT:  result_o = DATA_W'(is_lt);
        FN_LE:  result_o = DATA_W'(is_lt | is_eq);
        FN_GT:  result_o = DATA_W'(!(is_lt | is_eq));
        FN_GE:  result_o = DATA_W'(!is_lt);
        FN_SHL: result_o = src_a_i << sh_amt;
        FN_SHR: result_o = src_a_i >> sh_amt;
        default: result_o = '0;
      endcase
    end
  end

  assign valid_o = dec.valid;
endmodule

// File: rtl/flagless_alu_chk.sv
module flagless_alu_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned OP_W   = 6
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o
);
  logic in_range, is_cmp;
  always_comb begin
    in_range = (op_i >= 6'd10 && op_i <= 6'd25) || (op_i >= 6'd32 && op_i <= 6'd47);
    is_cmp   = (op_i >= 6'd17 && op_i <= 6'd22) || (op_i >= 6'd39 && op_i <= 6'd44);

    p_valid_range_r10: assert (valid_o == in_range)
      else $error("valid_o mismatch for opcode %0d", op_i);
    p_invalid_zero_r10: assert (valid_o || result_o == '0)
      else $error("nonzero result on undefined opcode %0d", op_i);
    p_cmp_boolean_r5: assert (!is_cmp || result_o <= DATA_W'(1))
      else $error("comparison result not boolean: %h", result_o);
    p_eq_reg_r6: assert (op_i != 6'd39 || result_o == DATA_W'(src_a_i == src_b_i))
      else $error("register eq wrong");
    p_not_imm_r9: assert (!(op_i == 6'd16 && imm_i == '1) || result_o == ~src_a_i)
      else $error("xor -1 is not complement");
    p_div_zero_r8: assert (!(((op_i == 6'd35 || op_i == 6'd47) && src_b_i == '0) ||
                            ((op_i == 6'd13 || op_i == 6'd25) && imm_i == '0)) ||
                           result_o == '0)
      else $error("zero divisor gave nonzero");
  end
endmodule

bind flagless_alu flagless_alu_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W)
) u_chk (
  .op_i     (op_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .imm_i    (imm_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/tb_flagless_alu.sv
module tb_flagless_alu;
  logic        clk = 1'b0;
  logic [5:0]  op;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic        vld;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  flagless_alu dut (
    .op_i(op), .src_a_i(a), .src_b_i(b), .imm_i(imm),
    .result_o(res), .valid_o(vld)
  );

  function automatic logic [32:0] ref_alu(input logic [5:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [15:0] im);
    logic [31:0] s, r;
    int          f;
    longint      sx, sy;
    if (o >= 10 && o <= 25) begin
      f = int'(o) - 10;
      s = {{16{im[15]}}, im};
    end else if (o >= 32 && o <= 47) begin
      f = int'(o) - 32;
      s = y;
    end else return 33'd0;
    sx = longint'($signed(x));
    sy = longint'($signed(s));
    case (f)
      0:  r = x + s;
      1:  r = x - s;
      2:  r = 32'(longint'(x) * longint'(s));
      3:  r = (sy == 0) ? 32'd0 : 32'(sx / sy);
      4:  r = x & s;
      5:  r = x | s;
      6:  r = x ^ s;
      7:  r = {31'd0, x == s};
      8:  r = {31'd0, x != s};
      9:  r = {31'd0, sx < sy};
      10: r = {31'd0, sx <= sy};
      11: r = {31'd0, sx > sy};
      12: r = {31'd0, sx >= sy};
      13: r = x << s[4:0];
      14: r = x >> s[4:0];
      default: r = (sy == 0) ? 32'd0 : 32'(sx % sy);
    endcase
    return {1'b1, r};
  endfunction

  function automatic string tag_of(input logic [5:0] o);
    if (o >= 10 && o <= 25) return "R1";
    if (o >= 32 && o <= 47) return "R2";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h: got v=%b r=%h exp v=%b r=%h",
               tag, op, a, b, imm, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic drive(input logic [5:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [15:0] im);
    @(negedge clk);
    op = o; a = x; b = y; imm = im;
    #1;
  endtask

  // direct check with a fixed expected value
  task automatic dchk(input string tag, input logic [5:0] o, input logic [31:0] x,
                      input logic [31:0] y, input logic [15:0] im, input logic [31:0] e,
                      input logic ev);
    drive(o, x, y, im);
    check(tag, {vld, res}, {ev, e});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'($urandom_range(0, 40));
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    op = '0; a = '0; b = '0; imm = '0;
    #1;
    check("R10", {vld, res}, 33'd0);  // idle state, opcode 0

    dchk("R1",  6'd10, 32'd5, 32'd0, 16'd7, 32'd12, 1'b1);
    dchk("R2",  6'd33, 32'd5, 32'd9, 16'd0, 32'hFFFF_FFFC, 1'b1);
    dchk("R3",  6'd14, 32'hFFFF_1234, 32'd0, 16'h8001, 32'hFFFF_0000, 1'b1);
    dchk("R3",  6'd10, 32'd0, 32'd0, 16'hFFFF, 32'hFFFF_FFFF, 1'b1);
    dchk("R4",  6'd32, 32'h7FFF_FFFF, 32'd1, 16'd0, 32'h8000_0000, 1'b1);
    dchk("R4",  6'd34, 32'h0001_0000, 32'h0001_0003, 16'd0, 32'h0003_0000, 1'b1);
    dchk("R5",  6'd41, 32'hFFFF_FFFF, 32'd1, 16'd0, 32'd1, 1'b1);
    dchk("R5",  6'd43, 32'hFFFF_FFFF, 32'd1, 16'd0, 32'd0, 1'b1);
    dchk("R5",  6'd20, 32'd10, 32'd0, 16'd10, 32'd1, 1'b1);
    dchk("R6",  6'd39, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'd0, 32'd1, 1'b1);
    dchk("R6",  6'd40, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'd0, 32'd0, 1'b1);
    dchk("R7",  6'd45, 32'd1, 32'd33, 16'd0, 32'd2, 1'b1);
    dchk("R7",  6'd46, 32'h8000_0000, 32'd31, 16'd0, 32'd1, 1'b1);
    dchk("R8",  6'd35, 32'hFFFF_FFF9, 32'd2, 16'd0, 32'hFFFF_FFFD, 1'b1);
    dchk("R8",  6'd47, 32'hFFFF_FFF9, 32'd2, 16'd0, 32'hFFFF_FFFF, 1'b1);
    dchk("R8",  6'd35, 32'd77, 32'd0, 16'd0, 32'd0, 1'b1);
    dchk("R8",  6'd25, 32'd77, 32'd0, 16'd0, 32'd0, 1'b1);
    dchk("R8",  6'd35, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0, 32'h8000_0000, 1'b1);
    dchk("R8",  6'd47, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0, 32'd0, 1'b1);
    dchk("R9",  6'd16, 32'h1234_5678, 32'd0, 16'hFFFF, 32'hEDCB_A987, 1'b1);
    dchk("R10", 6'd26, 32'd5, 32'd5, 16'd5, 32'd0, 1'b0);
    dchk("R10", 6'd48, 32'd5, 32'd5, 16'd5, 32'd0, 1'b0);
    dchk("R10", 6'd9,  32'd5, 32'd5, 16'd5, 32'd0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] o;
      logic [15:0] im;
      o  = 6'($urandom_range(0, 63));
      im = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 40)) : 16'($urandom);
      drive(o, pick(), pick(), im);
      check(tag_of(o), {vld, res}, ref_alu(op, a, b, imm));
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule